// File: doc/BRIEF.md
# Management Controller Watchdog

This block supervises a board management microcontroller from programmable logic. A prescaler turns the system clock into a slow tick of nominally one second. A tick counter runs from power-up onward and never stops. Every rising edge on the controller's strobe line clears both the prescaler and the tick counter. If the strobe stays quiet for the full timeout, nominally 96 ticks against a strobe roughly once a second, the counter expires and restarts from zero.

An expiry has consequences only once the block is armed. Arming happens when the controller reports that its management bus interfaces are enabled. An armed expiry does three things: it sends a fixed-length reset pulse to the controller, raises an isolation output that cuts the board off from the backplane management buses, and disarms the block. Isolation stays up until the restarted controller enables its bus interfaces again. An expiry while disarmed is counted but has no visible effect. Nothing is reported to the host processor.

Top module: `mgmt_watchdog`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, ctrl_reset_o and bus_isolate_o are 0 and the block is disarmed. A reset applied while isolation is high clears it.
- R2: With no strobe edge, an expiry occurs PRESCALE*TIMEOUT_TICKS clock edges after the counters were last cleared. An armed expiry raises ctrl_reset_o at that edge and not one edge earlier.
- R3: The strobe passes through a two-flop synchroniser. Only its rising edge counts, and that edge clears the prescaler and tick counter on the third clock edge after strobe_i goes high. A strobe held high restarts the count only once.
- R4: An expiry while disarmed drives neither ctrl_reset_o nor bus_isolate_o.
- R5: A rising edge on bus_en_i, after the same two-flop synchronisation, arms the block on the third clock edge after bus_en_i goes high. A falling edge has no effect.
- R6: An armed expiry drives ctrl_reset_o high for exactly RST_PULSE_CYC cycles and sets bus_isolate_o on the same edge. bus_isolate_o then stays high.
- R7: An armed expiry disarms the block. Later expiries produce no further reset pulse until the block is armed again.
- R8: Arming clears bus_isolate_o on the same edge.
- R9: If a strobe edge and the terminal tick fall in the same cycle, the strobe wins: no expiry occurs and the count restarts.
- R10: If an arming edge and an armed expiry fall in the same cycle, the expiry wins. The reset pulse is issued, isolation is set, and that arming edge is discarded.
- R11: After any expiry, armed or not, the counters restart from zero. The next expiry without a strobe comes a full timeout later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Keep-alive strobe from the controller (asynchronous) |
| bus_en_i | input | 1 | Controller reports management bus interfaces enabled (asynchronous level) |
| ctrl_reset_o | output | 1 | Active-high reset pulse to the controller |
| bus_isolate_o | output | 1 | High isolates the board from the backplane management buses |

## Verification
Two pairs of events can land on the same clock edge. A strobe edge can meet the terminal tick, and an arming edge can meet an armed expiry. The bench provokes the first pair with strobes spaced exactly one timeout apart, so the strobe's clear lands on the expiry edge. That case must give no pulse, while spacing one cycle wider must give a full pulse. The second pair is provoked by dropping and re-raising bus_en_i so the synchronised arming edge lands on the expiry edge. It is judged by a full reset pulse followed by isolation that stays high.

// File: rtl/mgwd_pkg.sv
// Shared types for the management watchdog.
package mgwd_pkg;
    // Arming state of the expiry consequence logic
    typedef enum logic {
        ARM_OFF = 1'b0,
        ARM_ON  = 1'b1
    } arm_e;
endpackage

// File: rtl/mgwd_edge_sync.sv
// Synchroniser with rising-edge detect.
// Assumes din is asynchronous to clk. rise lasts one cycle, STAGES+0 edges after din rises.
module mgwd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    // shift the input through the synchroniser plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    // rising edge of the synchronised level
    always_comb rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/mgwd_prescaler.sv
// Divides clk into a one-cycle tick every PRESCALE cycles.
// Assumes PRESCALE >= 2. clr restarts the division from zero.
module mgwd_prescaler #(
    parameter int PRESCALE = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pcnt;

    // terminal count of the divider
    always_comb tick = (pcnt == LAST);

    // count clock cycles, wrap at the terminal count or on clear
    always_ff @(posedge clk) begin
        if (!rst_n)             pcnt <= '0;
        else if (clr || tick)   pcnt <= '0;
        else                    pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/mgwd_timeout_ctr.sv
// Free-running tick counter that flags expiry after TIMEOUT_TICKS ticks.
// Assumes tick is a single-cycle pulse. clr overrides both counting and expiry.
module mgwd_timeout_ctr #(
    parameter int TIMEOUT_TICKS = 96,
    parameter int TW            = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic          expire,
    output logic [TW-1:0] tcnt
);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_TICKS - 1);

    // terminal tick reached with no competing clear
    always_comb expire = tick & (tcnt == LAST) & ~clr;

    // advance on each tick, restart at zero after the terminal tick
    always_ff @(posedge clk) begin
        if (!rst_n)      tcnt <= '0;
        else if (clr)    tcnt <= '0;
        else if (tick)   tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
    end
endmodule

// File: rtl/mgwd_pulse.sv
// Stretches a single-cycle trigger into a pulse of LEN cycles, starting on the next edge.
// Assumes the trigger does not repeat while a pulse is running.
module mgwd_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] remain;

    // load the length on trigger, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)               remain <= '0;
        else if (trig)            remain <= CW'(LEN);
        else if (remain != '0)    remain <= remain - 1'b1;
    end

    // output is high while cycles remain
    always_comb pulse = (remain != '0);
endmodule

// File: rtl/mgmt_watchdog.sv
// Always-running watchdog for a management controller.
// Counts PRESCALE*TIMEOUT_TICKS cycles between strobe edges. An expiry raises isolation and
// a controller reset pulse only when armed by a bus-enable edge. Assumes strobe_i and
// bus_en_i are asynchronous, and that reset is synchronous and active low.
module mgmt_watchdog #(
    parameter int PRESCALE      = 100_000_000,
    parameter int TIMEOUT_TICKS = 96,
    parameter int RST_PULSE_CYC = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic bus_en_i,
    output logic ctrl_reset_o,
    output logic bus_isolate_o
);
    import mgwd_pkg::*;

    localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;

    logic          strobe_rise;
    logic          arm_rise;
    logic          tick;
    logic          expire;
    logic [TW-1:0] tcnt;
    logic          fire;
    logic          armed_on;
    arm_e          arm_q;
    logic          iso_q;

    mgwd_edge_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
        .clk(clk), .rst_n(rst_n), .din(strobe_i), .rise(strobe_rise)
    );

    mgwd_edge_sync #(.STAGES(SYNC_STAGES)) u_arm_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_en_i), .rise(arm_rise)
    );

    mgwd_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(strobe_rise), .tick(tick)
    );

    mgwd_timeout_ctr #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .TW(TW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(strobe_rise), .tick(tick),
        .expire(expire), .tcnt(tcnt)
    );

    // expiry consequences apply only while armed
    always_comb begin
        armed_on = (arm_q == ARM_ON);
        fire     = expire & armed_on;
    end

    // arming and isolation: an expiry beats a simultaneous arming edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= ARM_OFF;
            iso_q <= 1'b0;
        end else if (fire) begin
            arm_q <= ARM_OFF;
            iso_q <= 1'b1;
        end else if (arm_rise) begin
            arm_q <= ARM_ON;
            iso_q <= 1'b0;
        end
    end

    mgwd_pulse #(.LEN(RST_PULSE_CYC)) u_rst_pulse (
        .clk(clk), .rst_n(rst_n), .trig(fire), .pulse(ctrl_reset_o)
    );

    // isolation output straight from its register
    always_comb bus_isolate_o = iso_q;
endmodule

// File: rtl/mgwd_checker.sv
// Property checker for mgmt_watchdog, attached by bind below.
// Observes the outputs plus the strobe clear, expiry, arming and tick-count nets.
module mgwd_checker #(
    parameter int RST_PULSE_CYC = 16,
    parameter int TW            = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_reset_o,
    input logic          bus_isolate_o,
    input logic          strobe_clr,
    input logic          expire,
    input logic          armed,
    input logic [TW-1:0] tcnt
);
    localparam int CW = $clog2(RST_PULSE_CYC + 1);

    logic [CW-1:0] hi_cnt;

    // number of cycles the reset pulse has been high so far
    always_ff @(posedge clk) begin
        if (!rst_n)            hi_cnt <= '0;
        else if (ctrl_reset_o) hi_cnt <= hi_cnt + 1'b1;
        else                   hi_cnt <= '0;
    end

    a_r6_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset_o |-> (hi_cnt < CW'(RST_PULSE_CYC)));

    a_r6_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_reset_o) |-> ($past(hi_cnt) == CW'(RST_PULSE_CYC - 1)));

    a_r6_iso_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_reset_o) |-> bus_isolate_o);

    a_r4_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !armed) |=> !$rose(ctrl_reset_o));

    a_r7_expiry_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && armed) |=> !armed);

    a_r8_arm_clears_iso: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> !bus_isolate_o);

    a_r9_strobe_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_clr |=> !$rose(ctrl_reset_o));

    a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (tcnt == '0));
endmodule

bind mgmt_watchdog mgwd_checker #(
    .RST_PULSE_CYC(RST_PULSE_CYC),
    .TW(TW)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .ctrl_reset_o(ctrl_reset_o),
    .bus_isolate_o(bus_isolate_o),
    .strobe_clr(strobe_rise),
    .expire(expire),
    .armed(armed_on),
    .tcnt(tcnt)
);

// File: tb/mgmt_watchdog_test.sv
// Self-checking bench: a scenario table walked by one loop, then directed tests.
// With PRESCALE=4 and TIMEOUT_TICKS=5, a strobe set at t=0 makes an expiry land on edge 23.
module mgmt_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int PRESCALE   = 4;
    localparam int TIMEOUT    = 5;
    localparam int RST_LEN    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic bus_en = 1'b0;
    logic ctrl_reset;
    logic bus_isolate;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    mgmt_watchdog #(
        .PRESCALE(PRESCALE), .TIMEOUT_TICKS(TIMEOUT), .RST_PULSE_CYC(RST_LEN), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .bus_en_i(bus_en),
        .ctrl_reset_o(ctrl_reset), .bus_isolate_o(bus_isolate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        bit armed;     // raise bus_en_i at t=0
        int period;    // strobe repeat period, 0 = strobe only at t=0
        int drop_at;   // cycle to drop bus_en_i, 0 = never
        int rise_at;   // cycle to raise bus_en_i, 0 = never
        int ncyc;      // cycles to run
        int pulses;    // expected number of sampled cycles with reset high
        bit iso;       // expected isolation at the end
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0,  0,  0,  0, 30, 0, 1'b0},
        '{1'b1,  0,  0,  0, 22, 0, 1'b0},
        '{1'b1,  0,  0,  0, 23, 1, 1'b1},
        '{1'b1,  0,  0,  0, 30, 3, 1'b1},
        '{1'b1,  0,  0,  0, 50, 3, 1'b1},
        '{1'b1, 15,  0,  0, 60, 0, 1'b0},
        '{1'b1, 20,  0,  0, 60, 0, 1'b0},
        '{1'b1, 21,  0,  0, 30, 3, 1'b1},
        '{1'b0,  0,  0, 10, 30, 3, 1'b1},
        '{1'b1,  0, 26, 30, 36, 3, 1'b0},
        '{1'b1,  0,  5, 20, 30, 3, 1'b1},
        '{1'b0,  0,  0, 30, 45, 3, 1'b1}
    };

    function automatic string req_of(int idx);
        case (idx)
            0:       return "R4 unarmed expiry";
            1:       return "R2 no early expiry";
            2:       return "R2 expiry edge";
            3:       return "R6 pulse length";
            4:       return "R7 disarm after expiry";
            5:       return "R3 periodic strobe";
            6:       return "R9 strobe meets expiry";
            7:       return "R9 strobe one cycle late";
            8:       return "R5 late arming";
            9:       return "R8 re-arm clears isolation";
            10:      return "R10 arm meets expiry";
            default: return "R11 restart after expiry";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; strobe = 1'b0; bus_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // runs one scenario from t=0 and returns the pulse count and final isolation
    task automatic run_case(input vec_t v, input bit hold_strobe, output int pulses, output bit iso);
        pulses = 0;
        strobe = 1'b1;
        bus_en = v.armed;
        for (int t = 1; t <= v.ncyc; t++) begin
            @(posedge clk);
            @(negedge clk);
            if (ctrl_reset) pulses++;
            strobe = hold_strobe | ((v.period != 0) && (t % v.period == 0));
            if (v.drop_at != 0 && v.drop_at == t) bus_en = 1'b0;
            if (v.rise_at != 0 && v.rise_at == t) bus_en = 1'b1;
        end
        iso = bus_isolate;
    endtask

    initial begin
        int   np;
        bit   fi;
        vec_t hv;

        // R1: outputs quiet while reset is held
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ctrl_reset == 1'b0, "R1 reset pulse low in reset", int'(ctrl_reset), 0);
        check(bus_isolate == 1'b0, "R1 isolation low in reset", int'(bus_isolate), 0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            run_case(VECS[i], 1'b0, np, fi);
            check(np == VECS[i].pulses, req_of(i), np, VECS[i].pulses);
            check(fi == VECS[i].iso, req_of(i), int'(fi), int'(VECS[i].iso));
        end

        // R1: reset while isolated clears isolation
        do_reset();
        run_case(VECS[3], 1'b0, np, fi);
        check(fi == 1'b1, "R1 isolation before reset", int'(fi), 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(bus_isolate == 1'b0, "R1 isolation cleared by reset", int'(bus_isolate), 0);
        check(ctrl_reset == 1'b0, "R1 reset pulse low after reset", int'(ctrl_reset), 0);
        rst_n = 1'b1;

        // R3: a strobe held high restarts the count only once
        do_reset();
        hv = '{1'b1, 0, 0, 0, 30, 3, 1'b1};
        run_case(hv, 1'b1, np, fi);
        check(np == 3, "R3 held strobe still expires", np, 3);
        check(fi == 1'b1, "R3 held strobe isolation", int'(fi), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule